// File: doc/BRIEF.md
# Two-Dimensional Single-Parity Product Encoder

This block turns a square frame of information bits into a product codeword. Information bits arrive one per cycle through a valid/ready input. They fill a K×K data block row by row. While the block fills, the encoder adds an even-parity bit to the end of every row. It keeps an even-parity bit for every column, and the row-parity column counts as a column here. The bottom-right bit is the parity of all the row-parity bits. It is equal to the parity of all the column-parity bits and to the parity of the whole data block. The result is an (K+1)×(K+1) array with even parity on every row and every column. Its code rate is (K/(K+1))² and its minimum distance is 4.

Once the last information bit is taken, the encoder stops accepting input and streams the whole array out on a single serial line. It reads the array column by column, and the row index advances fastest. A last marker tags the final bit, and a one-cycle done pulse follows it. Only one frame is held at a time. The next frame is accepted only after the readout ends. The size of the block is set by the parameter `K`, and the default of 5 gives a 25-bit frame and a 36-bit codeword.

Top module: `spc_product_enc`

## Requirements
- R1: `in_ready` is 1 while a frame is being collected and 0 during readout. An information bit is taken on a clock edge only when `in_valid` and `in_ready` are both 1, and `in_valid` low stalls the collection without losing any bit.
- R2: Accepted bit number i of a frame (counting from 0) becomes array element row i/K, column i%K. Rows and columns are numbered from 0.
- R3: Array element (r, K) for r < K is the XOR of the K information bits of row r, so every row has an even number of ones.
- R4: Array element (K, c) for c < K is the XOR of the K information bits of column c, so every column has an even number of ones.
- R5: The corner element (K, K) is the XOR of all K×K information bits. This equals the XOR of the row-parity bits and the XOR of the column-parity bits.
- R6: Readout starts in the cycle after the final information bit is accepted. It lasts N×N consecutive cycles with `out_valid` high, where N = K+1. Output bit l (from 0) is array element row l%N, column l/N.
- R7: `out_last` is 1 only on output bit N×N−1.
- R8: `frame_done` is a one-cycle pulse in the cycle right after the `out_last` bit. In that cycle `out_valid` is 0 and `in_ready` is 1 again.
- R9: `in_valid` and `in_bit` during readout have no effect on the codeword being sent or on the next frame.
- R10: A synchronous active-high `rst` sets `in_ready` to 1 and `out_valid`, `out_last` and `frame_done` to 0. It discards a partly collected frame, so the next accepted bit is bit 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Information bit present |
| in_bit | input | 1 | Information bit |
| in_ready | output | 1 | Encoder can take an information bit |
| out_valid | output | 1 | Codeword bit present |
| out_bit | output | 1 | Codeword bit, column-major order |
| out_last | output | 1 | Final codeword bit of the frame |
| frame_done | output | 1 | One-cycle pulse after the final codeword bit |

## Verification
The encoder is driven with seeded random frames and compared bit by bit against a codeword built by a bench function. Frames with an odd or even weight in each row and column make the row, column and corner parity bits differ from one another. All-zero and all-one frames pin the output order against the parity polarity. A single set bit at each far corner of the data block exposes a swap of row and column in the order or in the fill. Random gaps in `in_valid`, random traffic on the input during readout, and a reset in the middle of a frame show that only accepted bits reach the codeword.

// File: rtl/spc_product_enc.sv
module spc_product_enc #(
  parameter int K = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic out_valid,
  output logic out_bit,
  output logic out_last,
  output logic frame_done
);
  localparam int N  = K + 1;
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST_D = CW'(K - 1);
  localparam logic [CW-1:0] PIDX   = CW'(K);

  logic [N-1:0]  arr [K];
  logic [N-1:0]  colpar;
  logic          rowpar;
  logic          sending;
  logic          done_q;
  logic [CW-1:0] wr_r, wr_c, rd_r, rd_c;
  logic          take, row_end, row_bit;

  assign in_ready   = !sending;
  assign take       = in_valid && !sending;
  assign row_end    = (wr_c == LAST_D);
  assign row_bit    = rowpar ^ in_bit;
  assign out_valid  = sending;
  assign out_last   = sending && (rd_r == PIDX) && (rd_c == PIDX);
  assign out_bit    = (rd_r == PIDX) ? colpar[rd_c] : arr[rd_r][rd_c];
  assign frame_done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < K; r++) arr[r] <= '0;
      colpar  <= '0;
      rowpar  <= 1'b0;
      sending <= 1'b0;
      done_q  <= 1'b0;
      wr_r    <= '0;
      wr_c    <= '0;
      rd_r    <= '0;
      rd_c    <= '0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        arr[wr_r][wr_c] <= in_bit;
        colpar[wr_c]    <= colpar[wr_c] ^ in_bit;
        if (row_end) begin
          arr[wr_r][K] <= row_bit;
          colpar[K]    <= colpar[K] ^ row_bit;
          rowpar       <= 1'b0;
          wr_c         <= '0;
          if (wr_r == LAST_D) begin
            wr_r    <= '0;
            sending <= 1'b1;
          end else begin
            wr_r <= wr_r + 1'b1;
          end
        end else begin
          rowpar <= row_bit;
          wr_c   <= wr_c + 1'b1;
        end
      end else if (sending) begin
        if (rd_r == PIDX) begin
          rd_r <= '0;
          if (rd_c == PIDX) begin
            rd_c    <= '0;
            sending <= 1'b0;
            done_q  <= 1'b1;
            colpar  <= '0;
          end else begin
            rd_c <= rd_c + 1'b1;
          end
        end else begin
          rd_r <= rd_r + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spc_product_enc_chk.sv
module spc_product_enc_chk (
  input logic clk,
  input logic rst,
  input logic in_ready,
  input logic out_valid,
  input logic out_last,
  input logic frame_done
);
  // R1
  ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  // R6
  valid_run_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> out_valid);

  // R7
  last_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |=> (frame_done && !out_valid && in_ready));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R10
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !out_valid && !frame_done));
endmodule

bind spc_product_enc spc_product_enc_chk u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_last(out_last), .frame_done(frame_done)
);

// File: tb/tb_spc_product_enc.sv
module tb_spc_product_enc;
  localparam int K  = 5;
  localparam int N  = K + 1;
  localparam int KK = K * K;
  localparam int NN = N * N;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_ready, out_valid, out_bit, out_last, frame_done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spc_product_enc #(.K(K)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit),
    .out_last(out_last), .frame_done(frame_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input logic [KK-1:0] d, input int l);
    int r = l % N;
    int c = l / N;
    logic x = 1'b0;
    if (r < K && c < K) return d[r*K + c];
    for (int i = 0; i < K; i++)
      for (int j = 0; j < K; j++)
        if ((r == K || i == r) && (c == K || j == c)) x ^= d[i*K + j];
    return x;
  endfunction

  task automatic run_frame(input logic [KK-1:0] d, input bit gaps, input bit junk);
    int i = 0;
    while (i < KK) begin
      @(negedge clk);
      if (gaps && ($urandom % 3 == 0)) begin
        in_valid = 1'b0;
        in_bit   = ~d[i];
      end else begin
        in_valid = 1'b1;
        in_bit   = d[i];
      end
      check(in_ready === 1'b1 && out_valid === 1'b0, "R1 ready while collecting", in_ready, 1);
      @(posedge clk);
      if (in_valid) i++;
    end
    @(negedge clk);
    in_valid = junk;
    in_bit   = 1'($urandom);
    for (int l = 0; l < NN; l++) begin
      logic e = exp_bit(d, l);
      check(out_valid === 1'b1, "R6 valid run", out_valid, 1);
      check(in_ready === 1'b0, "R1 ready low in readout", in_ready, 0);
      if (l < K)
        check(out_bit === e, "R2 data placement", out_bit, e);
      else if (l % N == K && l != NN - 1)
        check(out_bit === e, "R4 column parity", out_bit, e);
      else if (l == NN - 1)
        check(out_bit === e, "R5 corner parity", out_bit, e);
      else if (l / N == K)
        check(out_bit === e, "R3 row parity", out_bit, e);
      else
        check(out_bit === e, "R6 column-major order", out_bit, e);
      check(out_last === (l == NN - 1), "R7 last marker", out_last, l == NN - 1);
      @(negedge clk);
      if (junk) begin
        in_valid = 1'($urandom);
        in_bit   = 1'($urandom);
      end
    end
    in_valid = 1'b0;
    check(frame_done === 1'b1, "R8 done pulse", frame_done, 1);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R8 idle after last", out_valid, 0);
    @(negedge clk);
    check(frame_done === 1'b0, "R8 done one cycle", frame_done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [KK-1:0] d;
    void'($urandom(32'd1729));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(in_ready === 1'b1, "R10 reset in_ready", in_ready, 1);
    check(out_valid === 1'b0 && out_last === 1'b0 && frame_done === 1'b0,
          "R10 reset outputs", out_valid, 0);

    run_frame('0, 1'b0, 1'b0);
    run_frame('1, 1'b0, 1'b0);
    run_frame(KK'(1), 1'b0, 1'b0);
    run_frame(KK'(1) << (KK - 1), 1'b0, 1'b0);
    run_frame(KK'(1) << (K - 1), 1'b0, 1'b0);
    run_frame(KK'(1) << (KK - K), 1'b0, 1'b0);

    // R10 reset mid-frame discards partial data
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_bit   = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(in_ready === 1'b1 && out_valid === 1'b0, "R10 reset mid-frame", out_valid, 0);
    d = KK'({$urandom, $urandom});
    run_frame(d, 1'b0, 1'b0);

    // R9 junk input during readout, R1 gaps
    for (int f = 0; f < 40; f++) begin
      d = KK'({$urandom, $urandom});
      run_frame(d, f[0], f[1]);
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule